// File: doc/BRIEF.md
# Read-Interlocked Data-Ready Flag

This block keeps the data-ready status bit of a sensor whose result registers a host reads over a serial bus. The sensor core raises a one-cycle pulse whenever a fresh sample exists. The bus decoder reports the first cycle of a register read burst, with its start address, and the last cycle of that burst. The block drives the ready bit the host polls, and a one-cycle load strobe that copies the newest sample into the readable result registers.

While a burst that targets the result registers is in progress, the load strobe is held back, so the host never reads half of one sample and half of the next. The ready bit drops when such a burst begins and cannot rise until the burst is over. A sample that arrives during the burst is remembered as pending. It is released as a single load strobe, and the ready bit is raised, in the cycle after the burst closes. Bursts that start at any other address leave the flag and the load path untouched.

Top module: `drdy_read_interlock`

## Requirements
- R1: With no guarded burst active and no guarded burst starting, a cycle with `smp_i`=1 gives `rdy_o`=1 and `load_o`=1 one cycle later.
- R2: A guarded burst begins when `rd_start_i`=1 with `rd_addr_i` in 0x08..0x0A or 0x0E..0x15 while no burst is active. One cycle later `rdy_o`=0 and `load_o`=0, whatever the previous value of `rdy_o`.
- R3: Through every cycle of a guarded burst, both `rdy_o` and `load_o` read 0, even when samples arrive.
- R4: A sample that arrives at any point of a guarded burst, including its start cycle and its end cycle, produces `rdy_o`=1 and `load_o`=1 one cycle after the cycle with `rd_end_i`=1. This holds whether `rdy_o` was 0 or 1 before the burst.
- R5: A guarded burst with no sample ends with `rdy_o`=0 and gives no load pulse.
- R6: However many samples arrive during one burst, exactly one load pulse lasting one cycle follows the burst.
- R7: `rd_start_i` with an address outside both windows is ignored: `rdy_o` keeps its value, and the following `rd_end_i` changes nothing.
- R8: `rd_start_i` during an active burst is ignored. `rd_end_i` with no active burst is ignored. When `rd_start_i` and `rd_end_i` are both 1 in an idle cycle, the start takes effect and the burst stays open.
- R9: Synchronous reset gives `rdy_o`=0 and `load_o`=0 and leaves no burst open. Outside a guarded burst and without a sample, `rdy_o` keeps its value and `load_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 1 | One-cycle pulse: a new sample is available |
| rd_start_i | input | 1 | First cycle of a register read burst |
| rd_end_i | input | 1 | Last cycle of a register read burst |
| rd_addr_i | input | ADDR_W | Start address of the burst, valid with `rd_start_i` |
| rdy_o | output | 1 | Data-ready bit seen by the host |
| load_o | output | 1 | One-cycle strobe that loads the sample into the result registers |

## Verification
Both outputs are registered once, so every result is due exactly one rising edge after the cycle in which the inputs that cause it are sampled. The bench drives inputs on the falling edge and checks one nanosecond after the next rising edge. A check therefore always sees the response to the stimulus of the preceding half period and nothing later. The sweeps cover every 8-bit start address, and every subset of sample arrival slots across a five-cycle burst from both initial flag values. For each, the expected flag and load strobe are computed from the window bounds and from whether any slot held a sample.

// File: rtl/drdy_pkg.sv
package drdy_pkg;

    localparam int ADDR_W_DEF  = 8;
    localparam int NUM_WIN_DEF = 2;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_e;

    // command from the burst tracker to the output register stage
    typedef struct packed {
        logic fire;   // load the sample and raise the flag
        logic clear;  // drop the flag
    } flag_cmd_t;

    function automatic logic addr_between(input logic [31:0] a,
                                          input logic [31:0] lo,
                                          input logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/drdy_addr_match.sv
module drdy_addr_match #(
    parameter int ADDR_W  = drdy_pkg::ADDR_W_DEF,
    parameter int NUM_WIN = drdy_pkg::NUM_WIN_DEF,
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LO = 16'h0E08,
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HI = 16'h150A
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);

    logic [NUM_WIN-1:0] hit_vec;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam logic [ADDR_W-1:0] LO = WIN_LO[i*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] HI = WIN_HI[i*ADDR_W +: ADDR_W];
        assign hit_vec[i] = drdy_pkg::addr_between(32'(addr_i), 32'(LO), 32'(HI));
    end

    assign hit_o = |hit_vec;

endmodule

// File: rtl/drdy_burst_track.sv
module drdy_burst_track
    import drdy_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      smp_i,
    input  logic      hit_start_i,
    input  logic      rd_end_i,
    output logic      in_burst_o,
    output logic      pend_o,
    output flag_cmd_t cmd_o
);

    burst_state_e st_q, st_n;
    logic         pend_q, pend_n;
    flag_cmd_t    cmd;

    always_comb begin
        st_n   = st_q;
        pend_n = pend_q;
        cmd    = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (hit_start_i) begin
                    // a sample in the start cycle already counts as mid-read
                    st_n      = ST_BURST;
                    cmd.clear = 1'b1;
                    pend_n    = smp_i;
                end else begin
                    cmd.fire = smp_i;
                    pend_n   = 1'b0;
                end
            end
            ST_BURST: begin
                if (rd_end_i) begin
                    st_n     = ST_IDLE;
                    cmd.fire = pend_q | smp_i;
                    pend_n   = 1'b0;
                end else begin
                    pend_n = pend_q | smp_i;
                end
            end
            default: begin
                st_n   = ST_IDLE;
                pend_n = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            pend_q <= pend_n;
        end
    end

    assign in_burst_o = (st_q == ST_BURST);
    assign pend_o     = pend_q;
    assign cmd_o      = cmd;

    // pending state exists only inside a burst (R6)
    p_pend_only_in_burst_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> !pend_q);

    // a sample seen mid-burst stays pending until the burst ends (R4)
    p_pend_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BURST && smp_i && !rd_end_i) |=> pend_q);

endmodule

// File: rtl/drdy_flag_reg.sv
module drdy_flag_reg
    import drdy_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_cmd_t cmd_i,
    output logic      rdy_o,
    output logic      load_o
);

    logic rdy_q, load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q  <= 1'b0;
            load_q <= 1'b0;
        end else begin
            load_q <= cmd_i.fire;
            if (cmd_i.fire) begin
                rdy_q <= 1'b1;
            end else if (cmd_i.clear) begin
                rdy_q <= 1'b0;
            end
        end
    end

    assign rdy_o  = rdy_q;
    assign load_o = load_q;

    // a load strobe is always accompanied by a raised flag (R1)
    p_load_with_flag_r1: assert property (@(posedge clk) disable iff (rst)
        load_q |-> rdy_q);

    // the strobe never lasts two cycles without a new command (R6)
    p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        (load_q && !cmd_i.fire) |=> !load_q);

endmodule

// File: rtl/drdy_read_interlock.sv
module drdy_read_interlock
    import drdy_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int NUM_WIN = NUM_WIN_DEF,
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LO = 16'h0E08,
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HI = 16'h150A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_i,
    input  logic              rd_start_i,
    input  logic              rd_end_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rdy_o,
    output logic              load_o
);

    logic      addr_hit;
    logic      hit_start;
    logic      in_burst;
    logic      pend;
    flag_cmd_t cmd;

    drdy_addr_match #(
        .ADDR_W (ADDR_W),
        .NUM_WIN(NUM_WIN),
        .WIN_LO (WIN_LO),
        .WIN_HI (WIN_HI)
    ) u_match (
        .addr_i(rd_addr_i),
        .hit_o (addr_hit)
    );

    assign hit_start = rd_start_i & addr_hit;

    drdy_burst_track u_track (
        .clk        (clk),
        .rst        (rst),
        .smp_i      (smp_i),
        .hit_start_i(hit_start),
        .rd_end_i   (rd_end_i),
        .in_burst_o (in_burst),
        .pend_o     (pend),
        .cmd_o      (cmd)
    );

    drdy_flag_reg u_flag (
        .clk   (clk),
        .rst   (rst),
        .cmd_i (cmd),
        .rdy_o (rdy_o),
        .load_o(load_o)
    );

    p_idle_sample_r1: assert property (@(posedge clk) disable iff (rst)
        (!in_burst && !hit_start && smp_i) |=> (rdy_o && load_o));

    p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (!in_burst && hit_start) |=> (!rdy_o && in_burst));

    p_burst_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        in_burst |-> (!rdy_o && !load_o));

    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (in_burst && rd_end_i && (pend || smp_i)) |=> (rdy_o && load_o));

    p_empty_end_r5: assert property (@(posedge clk) disable iff (rst)
        (in_burst && rd_end_i && !pend && !smp_i) |=> (!rdy_o && !load_o));

    p_miss_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (!in_burst && rd_start_i && !addr_hit && !smp_i)
            |=> (!in_burst && rdy_o == $past(rdy_o)));

    p_restart_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (in_burst && !rd_end_i) |=> in_burst);

endmodule

// File: tb/tb_drdy_read_interlock.sv
`timescale 1ns/1ps
module tb_drdy_read_interlock;

    localparam int WATCHDOG = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic       smp_i;
    logic       rd_start_i;
    logic       rd_end_i;
    logic [7:0] rd_addr_i;
    logic       rdy_o;
    logic       load_o;

    int n_chk  = 0;
    int n_fail = 0;
    int n_cyc  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    drdy_read_interlock dut (
        .clk       (clk),
        .rst       (rst),
        .smp_i     (smp_i),
        .rd_start_i(rd_start_i),
        .rd_end_i  (rd_end_i),
        .rd_addr_i (rd_addr_i),
        .rdy_o     (rdy_o),
        .load_o    (load_o)
    );

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc >= WATCHDOG && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", n_cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // drive on the falling edge, look 1 ns after the following rising edge
    task automatic cyc(input logic s, input logic st, input logic en, input logic [7:0] a);
        @(negedge clk);
        smp_i      = s;
        rd_start_i = st;
        rd_end_i   = en;
        rd_addr_i  = a;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    function automatic bit in_win(input int a);
        return (a >= 8 && a <= 10) || (a >= 14 && a <= 21);
    endfunction

    initial begin
        rst = 1'b1; smp_i = 0; rd_start_i = 0; rd_end_i = 0; rd_addr_i = '0;
        repeat (3) cyc(0, 0, 0, 8'h00);
        chk("R9 reset rdy", rdy_o, 1'b0);
        chk("R9 reset load", load_o, 1'b0);
        // a stray end and a sample while reset is still high
        cyc(1, 0, 1, 8'h00);
        chk("R9 reset holds rdy", rdy_o, 1'b0);
        @(negedge clk); rst = 1'b0;

        // R1 sample while idle
        cyc(1, 0, 0, 8'h00);
        chk("R1 rdy", rdy_o, 1'b1);
        chk("R1 load", load_o, 1'b1);
        cyc(0, 0, 0, 8'h00);
        chk("R9 rdy holds", rdy_o, 1'b1);
        chk("R9 load drops", load_o, 1'b0);
        cyc(0, 0, 1, 8'h00);
        chk("R8 stray end ignored", rdy_o, 1'b1);

        // R2 / R7 sweep of every start address with the flag raised
        for (int a = 0; a < 256; a++) begin
            cyc(1, 0, 0, 8'h00);
            cyc(0, 1, 0, 8'(a));
            chk(in_win(a) ? "R2 start clears" : "R7 miss keeps rdy", rdy_o, in_win(a) ? 1'b0 : 1'b1);
            chk("R3 load low at start", load_o, 1'b0);
            cyc(0, 0, 1, 8'h00);
            chk(in_win(a) ? "R5 empty end" : "R7 end after miss", rdy_o, in_win(a) ? 1'b0 : 1'b1);
            chk("R5 no load", load_o, 1'b0);
        end

        // R3 R4 R5 R6 sweep over sample slots of a five-cycle burst
        for (int init = 0; init < 2; init++) begin
            for (int m = 0; m < 32; m++) begin
                bit any;
                any = (m != 0);
                if (init == 1) begin
                    cyc(1, 0, 0, 8'h00);
                end else begin
                    cyc(0, 1, 0, 8'h10);
                    cyc(0, 0, 1, 8'h00);
                end
                chk("R9 setup rdy", rdy_o, init == 1);
                cyc(m[0], 1, 0, 8'h10);
                chk("R2 burst start rdy", rdy_o, 1'b0);
                chk("R3 start load", load_o, 1'b0);
                for (int k = 1; k < 4; k++) begin
                    cyc(m[k], 0, 0, 8'h00);
                    chk("R3 mid rdy", rdy_o, 1'b0);
                    chk("R3 mid load", load_o, 1'b0);
                end
                cyc(m[4], 0, 1, 8'h00);
                chk(any ? "R4 release rdy" : "R5 empty rdy", rdy_o, any);
                chk(any ? "R4 release load" : "R5 empty load", load_o, any);
                cyc(0, 0, 0, 8'h00);
                chk("R6 single pulse", load_o, 1'b0);
                chk("R9 rdy after burst", rdy_o, any);
            end
        end

        // R8 corner cases
        cyc(1, 0, 0, 8'h00);
        cyc(0, 1, 1, 8'h09);
        chk("R8 start wins over end", rdy_o, 1'b0);
        cyc(1, 0, 0, 8'h00);
        chk("R8 burst still open", rdy_o, 1'b0);
        cyc(0, 1, 0, 8'h40);
        chk("R8 restart ignored rdy", rdy_o, 1'b0);
        chk("R8 restart ignored load", load_o, 1'b0);
        cyc(0, 0, 1, 8'h00);
        chk("R4 deferred rdy", rdy_o, 1'b1);
        chk("R4 deferred load", load_o, 1'b1);
        // R7 miss with a sample in the same cycle acts as a plain sample
        cyc(0, 1, 0, 8'h0B);
        cyc(0, 0, 0, 8'h00);
        cyc(1, 1, 0, 8'h0D);
        chk("R7 miss with sample rdy", rdy_o, 1'b1);
        chk("R7 miss with sample load", load_o, 1'b1);
        // R6 sample in end cycle only, after a burst with no other sample
        cyc(0, 1, 0, 8'h15);
        cyc(1, 0, 1, 8'h00);
        chk("R4 end-cycle sample", load_o, 1'b1);
        cyc(0, 0, 0, 8'h00);
        chk("R6 one strobe", load_o, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule